// File: doc/BRIEF.md
# Sub-Rank Refresh Issue Scheduler

This memory-controller block decides when each sub-rank of one DRAM rank gets its refresh command. The eight banks of the rank are split into `NUM_SR` sub-ranks (2, 4 or 8). Within every refresh interval each sub-rank must receive exactly one refresh. The block runs its own free-running interval timer. It raises a refresh request that carries the target sub-rank number, and that number is driven onto the 3-bit bank-address field of the refresh command. The row address of that command is left as don't-care, because the device advances its own internal row counter.

Two orderings are available. In static mode the sub-ranks are served in ascending number, spaced evenly across the interval. In dynamic mode the per-sub-rank queue occupancy counts decide the order: a sub-rank whose queue is short is treated as idle and is refreshed early. Busy sub-ranks are deferred until a closing window near the end of the interval, where every sub-rank still unrefreshed is forced out. The block also keeps a 7-bit replica of the sub-array index being refreshed. The command scheduler reads it to avoid sub-array conflicts. This replica advances once per interval on time alone, so it stays in step with the device even when no refreshes are being acknowledged.

Top module: `subrank_refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ref_req` is 0, `ref_ba` is 0 and `sa_index` is 0.
- R2: In static mode (`mode_dyn`=0), sub-rank j becomes eligible when the interval phase reaches j*(TREFI/NUM_SR). Requests are issued in ascending order 0,1,…,NUM_SR-1, each at its own slot start.
- R3: In static mode the queue counts have no effect on the order or the timing of requests.
- R4: In dynamic mode (`mode_dyn`=1), an unrefreshed sub-rank whose count is at most IDLE_THRESH may be requested at any phase. Among several such sub-ranks, the lowest number goes first.
- R5: From phase TREFI-FORCE_MARGIN to the end of the interval, every unrefreshed sub-rank is forced. The lowest-numbered unrefreshed sub-rank wins, whatever its queue count, ahead of any idle sub-rank with a higher number.
- R6: A raised request stays high with `ref_ba` unchanged until the cycle in which `ref_ack` is sampled high. It then drops for at least one cycle, so only one refresh is ever outstanding.
- R7: Each sub-rank is requested at most once per interval. Once all are acknowledged, no request appears until the interval rolls over.
- R8: At the last phase of each interval (TREFI-1) the record of refreshed sub-ranks clears, and the next interval serves every sub-rank again.
- R9: `ref_ba` carries the sub-rank number in binary, and its bits above the number width are 0.
- R10: `sa_index` increments by one at each interval rollover and wraps from NUM_SA-1 to 0. It does so regardless of requests or acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dyn | input | 1 | 0 = static slotted order, 1 = idleness-driven order |
| q_count | input | NUM_SR*QCNT_W | Packed queue occupancy, sub-rank i in bits [i*QCNT_W +: QCNT_W] |
| ref_ack | input | 1 | Refresh command accepted by the command bus |
| ref_req | output | 1 | Refresh request pending |
| ref_ba | output | 3 | Target sub-rank number for the bank-address field |
| sa_index | output | 7 | Replica sub-array index being refreshed this interval |

## Verification
The checker watches properties on every cycle: request hold and address stability until acknowledge, the drop after an accepted refresh, and never requesting a sub-rank already marked done. It also checks that the done record only grows except when it clears, and that the sub-array replica moves only by one step or by a wrap. The ordering rules cannot be seen cycle by cycle and are left to the bench's scenarios. Those rules are the slot timing of static mode, the idle-first choice with lowest-number ties, the precedence of forced sub-ranks in the closing window, and the counter advancing while requests go unacknowledged. The bench observes them through the request phase and sub-rank number.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int SRR_BA_W  = 3;
    localparam int SRR_SA_W  = 7;
    localparam int SRR_MAX_SR = 8;

    typedef enum logic {
        SRR_STATIC  = 1'b0,
        SRR_DYNAMIC = 1'b1
    } srr_mode_e;

    typedef struct packed {
        logic                valid;
        logic [SRR_BA_W-1:0] id;
    } srr_pick_t;

    // Lowest set bit of an up-to-eight-wide vector.
    function automatic srr_pick_t srr_lowest(input logic [SRR_MAX_SR-1:0] vec);
        srr_pick_t p;
        p.valid = 1'b0;
        p.id    = '0;
        for (int i = SRR_MAX_SR - 1; i >= 0; i--) begin
            if (vec[i]) begin
                p.valid = 1'b1;
                p.id    = SRR_BA_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/srr_interval_timer.sv
module srr_interval_timer #(
    parameter int TREFI  = 3120,
    parameter int NUM_SA = 128,
    localparam int TW    = $clog2(TREFI)
) (
    input  logic                         clk,
    input  logic                         rst,
    output logic [TW-1:0]                phase,
    output logic                         rollover,
    output logic [srr_pkg::SRR_SA_W-1:0] sa_index
);
    import srr_pkg::*;

    localparam logic [TW-1:0]       LAST_PHASE = TW'(TREFI - 1);
    localparam logic [SRR_SA_W-1:0] LAST_SA    = SRR_SA_W'(NUM_SA - 1);

    assign rollover = (phase == LAST_PHASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            sa_index <= '0;
        end else if (rollover) begin
            phase    <= '0;
            sa_index <= (sa_index == LAST_SA) ? '0 : sa_index + 1'b1;
        end else begin
            phase    <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/srr_candidate_sel.sv
module srr_candidate_sel #(
    parameter int NUM_SR       = 4,
    parameter int QCNT_W       = 6,
    parameter int TREFI        = 3120,
    parameter int IDLE_THRESH  = 2,
    parameter int FORCE_MARGIN = 200,
    localparam int TW          = $clog2(TREFI)
) (
    input  logic [TW-1:0]            phase,
    input  srr_pkg::srr_mode_e       mode,
    input  logic [NUM_SR*QCNT_W-1:0] q_count,
    input  logic [NUM_SR-1:0]        done_mask,
    output srr_pkg::srr_pick_t       pick
);
    import srr_pkg::*;

    localparam int            SLOT      = TREFI / NUM_SR;
    localparam logic [TW-1:0] FORCE_AT  = TW'(TREFI - FORCE_MARGIN);
    localparam logic [QCNT_W-1:0] THR   = QCNT_W'(IDLE_THRESH);

    logic                  in_force;
    logic [NUM_SR-1:0]     force_vec;
    logic [NUM_SR-1:0]     opp_vec;

    assign in_force = (phase >= FORCE_AT);

    for (genvar i = 0; i < NUM_SR; i++) begin : g_sr
        localparam logic [TW-1:0] SLOT_START = TW'(i * SLOT);
        logic undone;
        logic idle;
        logic slot_open;
        assign undone    = ~done_mask[i];
        assign idle      = (q_count[i*QCNT_W +: QCNT_W] <= THR);
        assign slot_open = (phase >= SLOT_START);
        assign force_vec[i] = undone & in_force;
        assign opp_vec[i]   = undone & ((mode == SRR_DYNAMIC) ? idle : slot_open);
    end

    srr_pick_t force_pick;
    srr_pick_t opp_pick;

    always_comb begin
        force_pick = srr_lowest(SRR_MAX_SR'(force_vec));
        opp_pick   = srr_lowest(SRR_MAX_SR'(opp_vec));
        pick       = force_pick.valid ? force_pick : opp_pick;
    end

endmodule

// File: rtl/srr_issue.sv
module srr_issue #(
    parameter int NUM_SR = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rollover,
    input  srr_pkg::srr_pick_t           pick,
    input  logic                         ack,
    output logic                         req,
    output logic [srr_pkg::SRR_BA_W-1:0] ba,
    output logic [NUM_SR-1:0]            done_mask
);
    import srr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            ba        <= '0;
            done_mask <= '0;
        end else begin
            if (req && ack) begin
                req <= 1'b0;
                for (int i = 0; i < NUM_SR; i++) begin
                    if (ba == SRR_BA_W'(i)) done_mask[i] <= 1'b1;
                end
            end else if (!req && pick.valid) begin
                req <= 1'b1;
                ba  <= pick.id;
            end
            if (rollover) done_mask <= '0;
        end
    end

endmodule

// File: rtl/subrank_refresh_sched.sv
module subrank_refresh_sched #(
    parameter int NUM_SR       = 4,
    parameter int QCNT_W       = 6,
    parameter int TREFI        = 3120,
    parameter int IDLE_THRESH  = 2,
    parameter int FORCE_MARGIN = 200,
    parameter int NUM_SA       = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mode_dyn,
    input  logic [NUM_SR*QCNT_W-1:0]   q_count,
    input  logic                       ref_ack,
    output logic                       ref_req,
    output logic [2:0]                 ref_ba,
    output logic [6:0]                 sa_index
);
    import srr_pkg::*;

    localparam int TW = $clog2(TREFI);

    logic [TW-1:0]     phase;
    logic              rollover;
    logic [NUM_SR-1:0] done_mask;
    srr_pick_t         pick;
    srr_mode_e         mode;

    assign mode = srr_mode_e'(mode_dyn);

    srr_interval_timer #(
        .TREFI (TREFI),
        .NUM_SA(NUM_SA)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .rollover(rollover),
        .sa_index(sa_index)
    );

    srr_candidate_sel #(
        .NUM_SR      (NUM_SR),
        .QCNT_W      (QCNT_W),
        .TREFI       (TREFI),
        .IDLE_THRESH (IDLE_THRESH),
        .FORCE_MARGIN(FORCE_MARGIN)
    ) u_sel (
        .phase    (phase),
        .mode     (mode),
        .q_count  (q_count),
        .done_mask(done_mask),
        .pick     (pick)
    );

    srr_issue #(
        .NUM_SR(NUM_SR)
    ) u_issue (
        .clk      (clk),
        .rst      (rst),
        .rollover (rollover),
        .pick     (pick),
        .ack      (ref_ack),
        .req      (ref_req),
        .ba       (ref_ba),
        .done_mask(done_mask)
    );

endmodule

// File: rtl/subrank_refresh_sched_chk.sv
module subrank_refresh_sched_chk #(
    parameter int NUM_SR = 4,
    parameter int NUM_SA = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_req,
    input logic              ref_ack,
    input logic [2:0]        ref_ba,
    input logic [6:0]        sa_index,
    input logic [NUM_SR-1:0] done_mask
);

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_ack) |=> (ref_req && $stable(ref_ba)));

    assert_drop_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_ack) |=> !ref_req);

    assert_ba_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> (int'(ref_ba) < NUM_SR));

    assert_no_repeat_R7: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !(|(done_mask & (NUM_SR'(1) << ref_ba))));

    assert_mask_grow_or_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(done_mask) < $countones($past(done_mask))) |-> (done_mask == '0));

    assert_sa_step_R10: assert property (@(posedge clk) disable iff (rst)
        (sa_index != $past(sa_index)) |-> ((sa_index == $past(sa_index) + 7'd1) || (sa_index == 7'd0)));

    assert_sa_range_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(sa_index) < NUM_SA));

endmodule

bind subrank_refresh_sched subrank_refresh_sched_chk #(
    .NUM_SR(NUM_SR),
    .NUM_SA(NUM_SA)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_req  (ref_req),
    .ref_ack  (ref_ack),
    .ref_ba   (ref_ba),
    .sa_index (sa_index),
    .done_mask(done_mask)
);

// File: tb/subrank_refresh_sched_bench.sv
module subrank_refresh_sched_bench;

    localparam int NSR    = 4;
    localparam int QW     = 6;
    localparam int T      = 400;
    localparam int THR    = 2;
    localparam int MARGIN = 40;
    localparam int NSA    = 5;
    localparam int SLOT   = T / NSR;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mode_dyn = 1'b0;
    logic [NSR*QW-1:0] q_count = '0;
    logic            ref_ack = 1'b0;
    logic            ref_req;
    logic [2:0]      ref_ba;
    logic [6:0]      sa_index;

    int checks   = 0;
    int failures = 0;
    int edge_cnt = 0;
    int wd_cnt   = 0;

    always #5 clk = ~clk;

    subrank_refresh_sched #(
        .NUM_SR(NSR), .QCNT_W(QW), .TREFI(T),
        .IDLE_THRESH(THR), .FORCE_MARGIN(MARGIN), .NUM_SA(NSA)
    ) u_subrank_refresh_sched (
        .clk(clk), .rst(rst), .mode_dyn(mode_dyn), .q_count(q_count),
        .ref_ack(ref_ack), .ref_req(ref_req), .ref_ba(ref_ba), .sa_index(sa_index)
    );

    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
        wd_cnt <= wd_cnt + 1;
    end

    always @(posedge clk) begin
        if (wd_cnt > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", wd_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_q(input int sr, input int val);
        q_count[sr*QW +: QW] = QW'(val);
    endtask

    task automatic do_reset(input bit dyn);
        @(negedge clk);
        rst = 1'b1;
        ref_ack = 1'b0;
        mode_dyn = dyn;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait for a request, report id and decision phase, hold off ack for
    // 'hold' cycles (checking R6), then acknowledge for one cycle.
    task automatic grant(input int hold, output int id, output int ph);
        int n;
        n = 0;
        while (!ref_req && n < 3 * T) begin
            @(negedge clk);
            n++;
        end
        if (!ref_req) begin
            chk(1'b0, "R6 request timeout", 0, 1);
            id = -1;
            ph = -1;
            return;
        end
        id = int'(ref_ba);
        ph = (edge_cnt - 1) % T;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(ref_req && int'(ref_ba) == id, "R6 hold until ack", int'(ref_ba), id);
        end
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        chk(!ref_req, "R6 drop after ack", int'(ref_req), 0);
    endtask

    task automatic wait_quiet_to_rollover(input string tag);
        bit seen;
        seen = 1'b0;
        while ((edge_cnt % T) != 0) begin
            @(negedge clk);
            if (ref_req) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk(ref_req == 1'b0, "R1 req after reset", int'(ref_req), 0);
        chk(ref_ba == 3'd0, "R1 ba after reset", int'(ref_ba), 0);
        chk(sa_index == 7'd0, "R1 sa after reset", int'(sa_index), 0);
    endtask

    task automatic t_static(input bit idle_all);
        int id, ph;
        for (int s = 0; s < NSR; s++) set_q(s, idle_all ? 0 : (s == 2 ? 0 : 30));
        do_reset(1'b0);
        for (int s = 0; s < NSR; s++) begin
            grant((s == 0) ? 5 : 0, id, ph);
            chk(id == s, idle_all ? "R3 static order ignores counts" : "R2 static order", id, s);
            chk(ph == s * SLOT, "R2 static slot phase", ph, s * SLOT);
        end
        wait_quiet_to_rollover("R7 no request after all done");
        @(negedge clk);
        chk(sa_index == 7'd1, "R10 sa after first rollover", int'(sa_index), 1);
        grant(0, id, ph);
        chk(id == 0 && ph == 0, "R8 served again next interval", id, 0);
    endtask

    task automatic t_dyn_ties();
        int id, ph;
        for (int s = 0; s < NSR; s++) set_q(s, THR);
        do_reset(1'b1);
        for (int s = 0; s < NSR; s++) begin
            grant(0, id, ph);
            chk(id == s, "R4 idle tie lowest id", id, s);
            chk(ph == 2 * s, "R4 idle served at once", ph, 2 * s);
        end
        chk(ref_ba[2] == 1'b0 && ref_ba == 3'd3, "R9 ba field value", int'(ref_ba), 3);
    endtask

    task automatic t_dyn_force();
        int id, ph;
        set_q(0, 10); set_q(1, 10); set_q(2, 0); set_q(3, THR + 1);
        do_reset(1'b1);
        grant(0, id, ph);
        chk(id == 2 && ph == 0, "R4 idle ahead of busy", id, 2);
        grant(0, id, ph);
        chk(id == 0, "R5 forced lowest unrefreshed", id, 0);
        chk(ph == T - MARGIN, "R5 forced at window start", ph, T - MARGIN);
        set_q(3, 0);
        grant(0, id, ph);
        chk(id == 1, "R5 forced busy beats idle higher id", id, 1);
        grant(0, id, ph);
        chk(id == 3 && ph < T, "R5 last unrefreshed", id, 3);
    endtask

    task automatic t_sa_free_run();
        for (int s = 0; s < NSR; s++) set_q(s, 30);
        do_reset(1'b0);
        for (int i = 0; i < 7; i++) begin
            while (edge_cnt != T * i + 1) @(negedge clk);
            chk(int'(sa_index) == i % NSA, "R10 sa advances without acks", int'(sa_index), i % NSA);
        end
        chk(ref_req == 1'b1 && ref_ba == 3'd0, "R6 unacked request held", int'(ref_ba), 0);
    endtask

    initial begin
        t_reset();
        t_static(1'b0);
        t_static(1'b1);
        t_dyn_ties();
        t_dyn_force();
        t_sa_free_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule